// File: doc/BRIEF.md
# Correlator-Slope BFSK Level Detector

This block is a small non-coherent front end for binary frequency-shift keying. Each accepted input sample is multiplied by a local tone sample at one of the two signalling frequencies. The product feeds a leaky first-order recursive accumulator, which serves as the discrete correlator. When the received frequency matches the local tone, the accumulator output ramps steeply. When it does not, the output only wobbles.

The slope of the correlator output is measured with simple adders. The block takes the magnitude of the difference between the newest accumulator value and the value `WIN` samples earlier, then sums the last `WIN` such magnitudes with unit weights. The saturated sum is compared against a threshold register, giving one high/low level bit per sample. Any scale constant of the slope relation is folded into the threshold by the user, so the output side needs no multiplier. Tone generation, post-filtering and symbol timing sit outside this block.

Top module: `bfsk_slope_detector`

## Requirements
- R1: The product is the full-precision signed product of `in_sample` and `in_tone`, both two's complement `IN_W`-bit values.
- R2: On each cycle with `in_valid` high, the accumulator becomes `a_new = a - (a >>> LEAK) + product`. Here `>>>` is an arithmetic (floor) shift and `a` starts at 0 after reset.
- R3: The accumulator never overflows its width for any input sequence. Its magnitude stays below 2^(2*IN_W-1+LEAK).
- R4: The slope term of a sample is `|a_new - a_old|`, where `a_old` is the accumulator value stored `WIN` accepted samples earlier. Values before reset count as 0.
- R5: The slope measure is the sum of the slope terms of the last `WIN` accepted samples, with missing terms counted as 0. It is saturated to 2^THR_W - 1.
- R6: `level` is 1 when the saturated slope measure is strictly greater than `threshold`, sampled together with the sample, and 0 when it is equal or smaller.
- R7: `level` and `level_valid` update on the clock edge that accepts a sample. `level_valid` is high for exactly one cycle per accepted sample.
- R8: After reset, `level_valid` stays low for the first 2*WIN-1 accepted samples and rises from the 2*WIN-th accepted sample on.
- R9: A synchronous `rst` clears the accumulator, the delay history, the slope window, the fill count, `level` and `level_valid`.
- R10: While `in_valid` is low, `level_valid` is 0, `level` holds its value and no internal state changes, whatever is on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample and tone are accepted this cycle |
| in_sample | input | IN_W | Received signed sample |
| in_tone | input | IN_W | Local tone signed sample |
| threshold | input | THR_W | Unsigned decision threshold, already divided by the slope scale squared |
| level_valid | output | 1 | One-cycle strobe: `level` belongs to the last accepted sample |
| level | output | 1 | Detected binary level |

## Verification
Two functions meet in one cycle: the threshold decision on a slope sum and the saturation of that sum. They collide when the sum is clipped at its ceiling while the threshold sits at or just under that ceiling. The bench drives full-scale products of alternating sign until the reference model reports a clipped sum. It then presents the all-ones threshold, where the level must stay low, and the all-ones value minus one, where it must go high. A second collision, between a sample gap and an output strobe, is provoked by idling `in_valid` right after an accepted sample while the data pins carry noise. The bench then requires the level to hold and the model to stay in step afterwards.

// File: rtl/bfsk_slope_detector.sv
module bfsk_slope_detector #(
  parameter int IN_W  = 12,
  parameter int WIN   = 6,
  parameter int LEAK  = 4,
  parameter int THR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic [IN_W-1:0]  in_tone,
  input  logic [THR_W-1:0] threshold,
  output logic             level_valid,
  output logic             level
);

  localparam int PROD_W = 2 * IN_W;
  localparam int ACC_W  = 2 * IN_W + LEAK + 1;
  localparam int DIFF_W = ACC_W + 1;
  localparam int SUM_W  = DIFF_W + $clog2(WIN + 1);
  localparam int FILL   = 2 * WIN;
  localparam int CNT_W  = $clog2(FILL + 1);
  localparam logic signed [ACC_W-1:0] ACC_LIM = ACC_W'(1) <<< (2 * IN_W - 1 + LEAK);
  localparam logic [THR_W-1:0] THR_MAX = '1;

  logic signed [ACC_W-1:0]  hist [WIN];
  logic        [DIFF_W-1:0] mags [WIN-1];
  logic        [CNT_W-1:0]  cnt;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_nx;
  logic signed [DIFF_W-1:0] diff;
  logic        [DIFF_W-1:0] mag;
  logic        [SUM_W-1:0]  sum;
  logic        [THR_W-1:0]  sum_sat;

  assign prod   = $signed(in_sample) * $signed(in_tone);
  assign acc_nx = hist[0] - (hist[0] >>> LEAK) + ACC_W'(prod);
  assign diff   = DIFF_W'(acc_nx) - DIFF_W'(hist[WIN-1]);
  assign mag    = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);

  always_comb begin
    sum = SUM_W'(mag);
    for (int i = 0; i < WIN - 1; i++) sum = sum + SUM_W'(mags[i]);
  end

  generate
    if (SUM_W > THR_W) begin : g_clip
      assign sum_sat = (sum > SUM_W'(THR_MAX)) ? THR_MAX : sum[THR_W-1:0];
    end else begin : g_wide
      assign sum_sat = THR_W'(sum);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) hist[i] <= '0;
      for (int i = 0; i < WIN - 1; i++) mags[i] <= '0;
      cnt         <= '0;
      level       <= 1'b0;
      level_valid <= 1'b0;
    end else if (in_valid) begin
      hist[0] <= acc_nx;
      for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
      mags[0] <= mag;
      for (int i = 1; i < WIN - 1; i++) mags[i] <= mags[i-1];
      if (cnt < CNT_W'(FILL - 1)) cnt <= cnt + 1'b1;
      level       <= sum_sat > threshold;
      level_valid <= (cnt == CNT_W'(FILL - 1));
    end else begin
      level_valid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (hist[0] < ACC_LIM) && (hist[0] > -ACC_LIM)); // R3

  AST_STROBE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    level_valid |-> $past(in_valid)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(level) && !level_valid)); // R10

  AST_CEILING_NEVER_EXCEEDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && threshold == THR_MAX) |=> !level); // R5

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt < CNT_W'(FILL - 1)) |=> !level_valid); // R8

endmodule

// File: tb/bfsk_slope_detector_bench.sv
`timescale 1ns/1ps
module bfsk_slope_detector_bench;
  localparam int IN_W = 12, WIN = 6, LEAK = 4, THR_W = 24;
  localparam longint SMAX = (64'sd1 <<< THR_W) - 1;
  localparam logic signed [11:0] TONE8 [8] = '{12'sd0, 12'sd1448, 12'sd2047, 12'sd1448,
                                              12'sd0, -12'sd1448, -12'sd2047, -12'sd1448};
  // stimulus vectors: {sample phase step, tone phase step, amplitude shift, threshold}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{'{1,1,0,200000}, '{3,1,0,200000}, '{1,1,2,50000},
                                 '{2,1,0,4000000}, '{1,3,1,100000}, '{5,1,0,0}};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [IN_W-1:0] in_sample = '0, in_tone = '0;
  logic [THR_W-1:0] threshold = '0;
  logic level_valid, level;
  int errors = 0, checks = 0;

  bfsk_slope_detector #(.IN_W(IN_W), .WIN(WIN), .LEAK(LEAK), .THR_W(THR_W)) u_bfsk_slope_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .in_tone(in_tone),
    .threshold(threshold), .level_valid(level_valid), .level(level));

  always #2.5 clk = ~clk;

  longint m_hist [WIN];
  longint m_mag  [WIN];
  int     m_cnt;
  logic   m_level;

  function automatic longint m_sum(input int x, input int t);
    longint a, d, s;
    a = m_hist[0] - (m_hist[0] >>> LEAK) + longint'(x) * longint'(t);
    d = a - m_hist[WIN-1];
    s = (d < 0) ? -d : d;
    for (int i = 0; i < WIN - 1; i++) s += m_mag[i];
    return (s > SMAX) ? SMAX : s;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < WIN; i++) begin m_hist[i] = 0; m_mag[i] = 0; end
    m_cnt = 0; m_level = 0;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int x, input int t, input longint thr, input string req);
    longint a, d, s;
    logic ev;
    s = m_sum(x, t);
    a = m_hist[0] - (m_hist[0] >>> LEAK) + longint'(x) * longint'(t);
    d = a - m_hist[WIN-1];
    for (int i = WIN - 1; i > 0; i--) begin m_hist[i] = m_hist[i-1]; m_mag[i] = m_mag[i-1]; end
    m_hist[0] = a; m_mag[0] = (d < 0) ? -d : d;
    m_cnt++;
    ev = (m_cnt >= 2 * WIN);
    m_level = (s > thr);
    in_sample = IN_W'(x); in_tone = IN_W'(t); threshold = THR_W'(thr); in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0;
    check({req, " R7 R8 strobe"}, level_valid, ev);
    if (ev) check({req, " R6 level"}, level, m_level);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (2) @(posedge clk);
    #1; rst = 0; m_clear();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint s;
    logic held;
    m_clear();
    do_reset();
    // R9: reset state
    check("R9 reset strobe", level_valid, 0);
    check("R9 reset level", level, 0);

    // table walk: R1 R2 R4 R5 R6 under matched, mismatched and scaled tones
    foreach (VEC[v]) begin
      for (int n = 0; n < 24; n++) begin
        int x, t;
        x = TONE8[(n * VEC[v][0]) % 8] >>> VEC[v][2];
        t = TONE8[(n * VEC[v][1]) % 8];
        step(x, t, VEC[v][3], "R2 R4 table");
      end
    end

    // R10: idle with noise on the data pins
    held = level;
    in_sample = 12'h7ff; in_tone = 12'h800; threshold = '0;
    repeat (4) begin
      @(posedge clk); #1;
      check("R10 idle strobe", level_valid, 0);
      check("R10 idle level", level, held);
    end
    for (int n = 0; n < 10; n++) step(TONE8[n % 8], TONE8[n % 8], 300000, "R10 resume");

    // R6: threshold equality and one below
    s = m_sum(1000, 1500);
    step(1000, 1500, s, "R6 equal");
    check("R6 equal gives low", level, 0);
    s = m_sum(1000, 1500);
    step(1000, 1500, s - 1, "R6 one below");
    check("R6 one below gives high", level, 1);

    // R5 with R1 sign: full-scale products of alternating sign drive the sum into clipping
    for (int n = 0; n < 60; n++) step(-2048, -2048, SMAX, "R1 R3 positive ramp");
    for (int n = 0; n < 40 && m_sum(2047, -2048) < SMAX; n++) step(2047, -2048, SMAX, "R1 negative swing");
    check("R5 sum clipped in model", m_sum(2047, -2048), SMAX);
    step(2047, -2048, SMAX, "R5 ceiling threshold");
    check("R5 ceiling gives low", level, 0);
    step(2047, -2048, SMAX - 1, "R5 ceiling minus one");
    check("R5 ceiling minus one gives high", level, 1);

    // R9 R8: reset mid-stream, fill count restarts
    do_reset();
    check("R9 mid reset strobe", level_valid, 0);
    check("R9 mid reset level", level, 0);
    for (int n = 0; n < 2 * WIN + 3; n++) step(TONE8[n % 8], TONE8[n % 8], 100000, "R8 refill");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule